// File: doc/BRIEF.md
# Dual-Channel Direct Digital Waveform Synthesiser

This block turns a single clock into a periodic digital waveform whose frequency is set by a control word. An 11-bit phase register advances by the control word on every clock and wraps when it overflows. Its upper 8 bits select a point within one waveform period. That point is turned into an 8-bit sample of a sine, a triangle or a square wave. The sine comes from a table built inside the RTL. The triangle and square are formed directly from the phase bits.

A two-bit amplitude code attenuates the sample in steps of 6 dB by shifting it right. A second output channel reads the same phase plus a programmable 8-bit offset. It gives a copy of the waveform shifted in phase by a known amount. Both channels share the same latency. The two streams are meant to drive a pair of DACs directly.

Top module: `dds_phase_gen`

## Requirements
- R1: While `rst_n` is low, both sample outputs are 8'h00 and the phase register holds 0. The first sample after reset is taken at phase 0.
- R2: On each rising clock edge the 11-bit phase register adds the effective step, modulo 2048. A new `freq_word` is used from the next edge on, and the phase reached so far is kept.
- R3: The effective step is `freq_word` limited to 1024, which is half the clock rate. Any value above 1024 steps exactly like 1024.
- R4: The lookup address is phase bits [10:3]. The sample for a phase is visible on the outputs one clock edge after the edge at which the register holds that phase.
- R5: With `wave_sel` = 2'b00 (sine), the sample at address a is floor(128.5 + 127·sin(2πa/256)).
- R6: With `wave_sel` = 2'b01 (triangle), the sample is 2a for a < 128 and 2·(255−a) for a ≥ 128.
- R7: With `wave_sel` = 2'b10 (square), the sample is 8'h00 for a < 128 and 8'hFF for a ≥ 128.
- R8: With `wave_sel` = 2'b11, both outputs carry the mid-scale value 8'h80, whatever the amplitude code.
- R9: `amp_code` values 0, 1, 2 and 3 shift the selected sample right by 0, 1, 2 and 3 bits, with zeros filled in at the top.
- R10: Channel B uses the address (a + `phase_ofs`) mod 256, with the same latency as channel A. With an offset of 0 the two channels are identical.
- R11: For a fixed step K, the output sequence repeats every 2048/gcd(2048, K) clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| freq_word | input | 11 | Phase step added each clock |
| phase_ofs | input | 8 | Address offset of channel B |
| wave_sel | input | 2 | Waveform: 00 sine, 01 triangle, 10 square, 11 mid-scale |
| amp_code | input | 2 | Right-shift count applied to the sample |
| samp_a | output | 8 | Channel A sample |
| samp_b | output | 8 | Channel B sample (phase-shifted) |

## Verification
Waveform select, amplitude code and phase offset are sampled at the same edge that loads the output register, so they act on the outputs one edge after they are applied. A new frequency word changes the phase at the next edge, so it first affects the sample seen two edges later. The bench drives every input on the falling edge. It keeps a reference phase that advances at each rising edge, and from it computes the sample each output should hold after that edge. It then compares the outputs on the next falling edge, exactly one register stage behind the reference, which matches the single output register.

// File: rtl/dds_pkg.sv
package dds_pkg;

  typedef enum logic [1:0] {
    WAVE_SINE = 2'b00,
    WAVE_TRI  = 2'b01,
    WAVE_SQR  = 2'b10,
    WAVE_MID  = 2'b11
  } wave_e;

  // Sine table entry: offset-binary, centred on mid-scale, swing mid-1.
  function automatic logic [15:0] sine_entry(input int idx, input int depth, input int width);
    real ang;
    real mid;
    int  val;
    mid = real'(1 << (width - 1));
    ang = 2.0 * 3.14159265358979 * real'(idx) / real'(depth);
    val = $rtoi((mid - 1.0) * $sin(ang) + mid + 0.5);
    return 16'(val);
  endfunction

endpackage

// File: rtl/dds_accum.sv
module dds_accum #(
  parameter int ACC_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq_word,
  output logic [ACC_W-1:0] phase_q
);
  localparam logic [ACC_W-1:0] STEP_MAX = ACC_W'(1) << (ACC_W - 1);

  logic [ACC_W-1:0] step_eff;
  logic [ACC_W-1:0] phase_d;

  always_comb begin
    step_eff = (freq_word > STEP_MAX) ? STEP_MAX : freq_word;
    phase_d  = phase_q + step_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/dds_channel.sv
module dds_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] ofs_i,
  input  logic [1:0]   wave_sel,
  input  logic [1:0]   amp_code,
  output logic [W-1:0] samp_o
);
  import dds_pkg::*;

  localparam int          DEPTH = 1 << W;
  localparam logic [W-1:0] MID  = W'(1) << (W - 1);

  logic [W-1:0] tbl [DEPTH];
  logic [W-1:0] addr;
  logic [W-1:0] sine_v;
  logic [W-1:0] tri_v;
  logic [W-1:0] sqr_v;
  logic [W-1:0] pick;
  logic [W-1:0] samp_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
    assign tbl[i] = W'(sine_entry(i, DEPTH, W));
  end

  always_comb begin
    addr   = addr_i + ofs_i;
    sine_v = tbl[addr];
    tri_v  = addr[W-1] ? {~addr[W-2:0], 1'b0} : {addr[W-2:0], 1'b0};
    sqr_v  = {W{addr[W-1]}};
    unique case (wave_e'(wave_sel))
      WAVE_SINE: pick = sine_v;
      WAVE_TRI:  pick = tri_v;
      WAVE_SQR:  pick = sqr_v;
      default:   pick = MID;
    endcase
    samp_d = (wave_e'(wave_sel) == WAVE_MID) ? MID : (pick >> amp_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_o <= '0;
    else        samp_o <= samp_d;
  end
endmodule

// File: rtl/dds_phase_gen.sv
module dds_phase_gen #(
  parameter int ACC_W = 11,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq_word,
  input  logic [W-1:0]     phase_ofs,
  input  logic [1:0]       wave_sel,
  input  logic [1:0]       amp_code,
  output logic [W-1:0]     samp_a,
  output logic [W-1:0]     samp_b
);
  localparam int NCH = 2;

  logic [ACC_W-1:0] phase_q;
  logic [W-1:0]     base_addr;
  logic [W-1:0]     ch_samp [NCH];

  dds_accum #(.ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .freq_word (freq_word),
    .phase_q   (phase_q)
  );

  assign base_addr = phase_q[ACC_W-1 -: W];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [W-1:0] ofs;
    if (c == 0) begin : g_ref
      assign ofs = '0;
    end else begin : g_shift
      assign ofs = phase_ofs;
    end
    dds_channel #(.W(W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_i   (base_addr),
      .ofs_i    (ofs),
      .wave_sel (wave_sel),
      .amp_code (amp_code),
      .samp_o   (ch_samp[c])
    );
  end

  assign samp_a = ch_samp[0];
  assign samp_b = ch_samp[1];
endmodule

// File: rtl/dds_phase_gen_chk.sv
module dds_phase_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] phase_ofs,
  input logic [1:0] wave_sel,
  input logic [1:0] amp_code,
  input logic [7:0] samp_a,
  input logic [7:0] samp_b
);
  AST_MID_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_sel == 2'b11) |=> (samp_a == 8'h80 && samp_b == 8'h80)); // R8

  AST_DEEP_ATTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_code == 2'b11 && wave_sel != 2'b11) |=> (samp_a < 8'd32 && samp_b < 8'd32)); // R9

  AST_SQUARE_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_sel == 2'b10) |=> (samp_a == 8'h00 || samp_a == (8'hFF >> $past(amp_code)))); // R7

  AST_ZERO_OFFSET_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_ofs == 8'h00) |=> (samp_a == samp_b)); // R10
endmodule

bind dds_phase_gen dds_phase_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase_ofs (phase_ofs),
  .wave_sel  (wave_sel),
  .amp_code  (amp_code),
  .samp_a    (samp_a),
  .samp_b    (samp_b)
);

// File: tb/sim_dds_phase_gen.sv
`timescale 1ns/1ps
module sim_dds_phase_gen;
  logic        clk;
  logic        rst_n;
  logic [10:0] freq_word;
  logic [7:0]  phase_ofs;
  logic [1:0]  wave_sel;
  logic [1:0]  amp_code;
  logic [7:0]  samp_a;
  logic [7:0]  samp_b;

  int n_cmp = 0;
  int n_bad = 0;

  dds_phase_gen u0 (
    .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .phase_ofs(phase_ofs),
    .wave_sel(wave_sel), .amp_code(amp_code), .samp_a(samp_a), .samp_b(samp_b)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] ref_sine(input logic [7:0] a);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * real'(a) / 256.0) + 128.5;
    return 8'($rtoi(v));
  endfunction

  function automatic logic [7:0] ref_samp(input logic [7:0] a, input logic [1:0] sel,
                                          input logic [1:0] amp);
    logic [7:0] s;
    case (sel)
      2'b00: s = ref_sine(a);
      2'b01: s = (a < 8'd128) ? 8'(2 * a) : 8'(2 * (255 - a));
      2'b10: s = (a < 8'd128) ? 8'h00 : 8'hFF;
      default: return 8'h80;
    endcase
    return s >> amp;
  endfunction

  // Reference phase and expected outputs, one register stage like the outputs.
  logic [10:0] m_phase;
  logic [7:0]  exp_a, exp_b;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= '0; exp_a <= '0; exp_b <= '0;
    end else begin
      exp_a   <= ref_samp(m_phase[10:3], wave_sel, amp_code);
      exp_b   <= ref_samp(8'(m_phase[10:3] + phase_ofs), wave_sel, amp_code);
      m_phase <= m_phase + ((freq_word > 11'd1024) ? 11'd1024 : freq_word);
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run(input int n, input string tag);
    repeat (n) begin
      @(negedge clk);
      chk(tag, samp_a, exp_a);
      chk({tag, "/R10"}, samp_b, exp_b);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] hist [32];
    void'($urandom(32'h5EED_D5D5));
    rst_n = 1'b0; freq_word = 11'd8; phase_ofs = 8'd0; wave_sel = 2'b00; amp_code = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1", samp_a, 8'h00);
    chk("R1", samp_b, 8'h00);
    rst_n = 1'b1;
    // R4: first sample after release is phase 0, next is address 1
    @(negedge clk); chk("R4", samp_a, ref_sine(8'd0));
    @(negedge clk); chk("R4", samp_a, ref_sine(8'd1));
    run(300, "R5");
    wave_sel = 2'b01; run(300, "R6");
    wave_sel = 2'b10; run(300, "R7");
    wave_sel = 2'b11; amp_code = 2'b10; run(20, "R8");
    wave_sel = 2'b01;
    for (int k = 0; k < 4; k++) begin
      amp_code = 2'(k); run(100, "R9");
    end
    amp_code = 2'b00; wave_sel = 2'b00; phase_ofs = 8'd64; run(300, "R10");
    phase_ofs = 8'd200; wave_sel = 2'b10; run(300, "R10");
    freq_word = 11'd2000; run(20, "R3");
    freq_word = 11'd2047; run(20, "R3");
    freq_word = 11'd1024; run(20, "R3");
    freq_word = 11'd37; run(50, "R2");
    freq_word = 11'd1; run(50, "R2");
    freq_word = 11'd0; run(10, "R2");
    freq_word = 11'd5; run(600, "R2");
    // R11: step 64 gives a period of 32 clocks
    freq_word = 11'd64; wave_sel = 2'b00; run(5, "R11");
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); hist[i] = samp_a;
    end
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); chk("R11", samp_a, hist[i]);
    end
    // constrained random
    for (int blk = 0; blk < 300; blk++) begin
      freq_word = 11'($urandom_range(0, 2047));
      phase_ofs = 8'($urandom);
      wave_sel  = 2'($urandom);
      amp_code  = 2'($urandom);
      run(int'($urandom_range(1, 12)), "R2");
    end
    // reset mid-run returns to phase 0
    rst_n = 1'b0;
    @(negedge clk); chk("R1", samp_a, 8'h00); chk("R1", samp_b, 8'h00);
    rst_n = 1'b1; run(40, "R1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule